// File: doc/BRIEF.md
# Prescaled Up-Counter with Control Register

This block is a free-running up-counter for a timer subsystem. A small bus port reaches two registers: the count itself and a control byte. When the enable bit is set, the counter advances from the bus clock through a prescale divider. A stop-in-wait bit can also freeze everything while the chip's wait-mode input is high.

The same divider produces a one-cycle tick every 64 running cycles. A neighbouring pulse accumulator consumes this tick. Because the tick comes from the divider, it disappears whenever the counter is halted.

Software can always read the count, either as one coherent 16-bit word or as single bytes. Writes to the count only take effect while the test-mode input is high. The control byte also keeps three further bits that software can read and write. They have no effect on counting here.

The bus is big-endian within a 16-bit word. The address is a byte offset and its bit 0 is ignored. Byte lane 1 (`bus_be[1]`, data bits 15:8) carries the even offset, and lane 0 carries the odd offset.

Top module: `ptimer_core`

## Requirements
- R1: After a synchronous reset the count is 0x0000, the control byte is 0x00, `acc_tick` is 0 and `bus_rdata` is 0x0000, so the timer starts halted.
- R2: While running, the count rises by exactly one every clock and wraps from 0xFFFF to 0x0000. Running means control bit 15 (enable) is 1 and not both control bit 14 (stop-in-wait) and `wait_mode` are 1.
- R3: With the enable bit at 0, the count, the 6-bit divider and `acc_tick` all stay frozen.
- R4: With the stop-in-wait bit at 1 and `wait_mode` high, the count, divider and tick freeze. With that bit at 0, counting goes on through wait mode.
- R5: `acc_tick` is a one-cycle pulse after every 64th running cycle, when the divider wraps from 63 to 0. A halted divider resumes from the value where it stopped.
- R6: A read at offset 4 with both lanes enabled returns, on the next cycle, the count held in the clock of the read. The high byte is in bits 15:8.
- R7: A read at offset 4 with one lane enabled returns that byte in its own lane and zero in the disabled lane.
- R8: A write at offset 4 while `test_mode` is 0 leaves the count unchanged apart from its normal counting.
- R9: A write at offset 4 while `test_mode` is 1 loads the enabled lanes. The loaded value is visible in the next cycle, and the other lane keeps its value for that cycle. Counting then continues from the new value without clearing the divider.
- R10: The control byte lives at offset 6 on lane 1: bit 15 enable, bit 14 stop-in-wait, bits 13:11 stored only, bits 10:8 read as 0. Lane 0 at offset 6 reads 0 and ignores writes.
- R11: In a cycle after one with no read strobe, `bus_rdata` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte offset; bit 0 ignored |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 2 | Byte lane enables (1 = bits 15:8) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| wait_mode | input | 1 | Chip wait-mode indication |
| test_mode | input | 1 | Enables writes to the count |
| count | output | 16 | Current count |
| acc_tick | output | 1 | Divide-by-64 pulse for an accumulator |

## Verification
A wrong divider state shows first at `acc_tick`, where a pulse lands on the wrong cycle within at most 64 running clocks. A wrong count or a wrong run decision is visible on `count` one clock after the faulty edge. That includes a missed freeze in wait mode or a write accepted outside test mode. The bench compares both outputs and the read data against a behavioural model on every clock, so any divergence is caught in the cycle it reaches a port.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  // Byte offsets of the two register words
  localparam int CNT_OFS = 4;
  localparam int CTL_OFS = 6;
  localparam int CTL_BITS = 5;

  typedef struct packed {
    logic enable;
    logic stop_wait;
    logic frz_store;
    logic ffc_store;
    logic prec_store;
  } ctl_t;
endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int DIV_W   = 6,
  parameter int PS_LOG2 = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic inc,
  output logic tick
);
  localparam logic [DIV_W-1:0] DIV_TOP = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= run && (div_q == DIV_TOP);
      if (run) div_q <= div_q + 1'b1;
    end
  end

  generate
    if (PS_LOG2 == 0) begin : g_ratio_one
      assign inc = run;
    end else begin : g_ratio_pow2
      assign inc = run && (&div_q[PS_LOG2-1:0]);
    end
  endgenerate

  assert_tick_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(run));
  assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  assert_div_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(div_q));
endmodule

// File: rtl/ptimer_counter.sv
module ptimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             ld_hi,
  input  logic             ld_lo,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);
  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld_hi || ld_lo) begin
      if (ld_hi) cnt[CNT_W-1:HALF] <= ld_val[CNT_W-1:HALF];
      if (ld_lo) cnt[HALF-1:0]     <= ld_val[HALF-1:0];
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_hi && !ld_lo) |=> cnt == $past(cnt) + 1'b1);
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld_hi && !ld_lo) |=> $stable(cnt));
endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        be,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              test_mode,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rdata,
  output logic              ld_hi,
  output logic              ld_lo,
  output ctl_t              ctl
);
  localparam int HALF = CNT_W / 2;
  localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(CNT_OFS);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);

  logic sel_cnt, sel_ctl;
  logic [CNT_W-1:0] rd_mux;

  assign sel_cnt = addr[ADDR_W-1:1] == CNT_A[ADDR_W-1:1];
  assign sel_ctl = addr[ADDR_W-1:1] == CTL_A[ADDR_W-1:1];
  assign ld_hi = wr && test_mode && sel_cnt && be[1];
  assign ld_lo = wr && test_mode && sel_cnt && be[0];

  always_comb begin
    rd_mux = '0;
    if (sel_cnt) begin
      if (be[1]) rd_mux[CNT_W-1:HALF] = cnt[CNT_W-1:HALF];
      if (be[0]) rd_mux[HALF-1:0]     = cnt[HALF-1:0];
    end else if (sel_ctl && be[1]) begin
      rd_mux[CNT_W-1:HALF] = {ctl, {(HALF-CTL_BITS){1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      rdata <= '0;
    end else begin
      rdata <= rd ? rd_mux : '0;
      if (wr && sel_ctl && be[1]) ctl <= wdata[CNT_W-1 -: CTL_BITS];
    end
  end

  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0);
  assert_ctl_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (rd && sel_ctl) |=> rdata[CNT_W-CTL_BITS-1:0] == '0);
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
  import ptimer_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 16,
  parameter int DIV_W   = 6,
  parameter int PS_LOG2 = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_be,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              wait_mode,
  input  logic              test_mode,
  output logic [CNT_W-1:0]  count,
  output logic              acc_tick
);
  ctl_t ctl;
  logic run, inc, ld_hi, ld_lo;

  assign run = ctl.enable && !(ctl.stop_wait && wait_mode);

  ptimer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .be(bus_be), .wdata(bus_wdata), .test_mode(test_mode), .cnt(count),
    .rdata(bus_rdata), .ld_hi(ld_hi), .ld_lo(ld_lo), .ctl(ctl)
  );

  ptimer_prescaler #(.DIV_W(DIV_W), .PS_LOG2(PS_LOG2)) u_presc (
    .clk(clk), .rst(rst), .run(run), .inc(inc), .tick(acc_tick)
  );

  ptimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_val(bus_wdata), .cnt(count)
  );

  assert_nowrite_normal_R8: assert property (@(posedge clk) disable iff (rst)
    (!test_mode && !inc) |=> $stable(count));
  assert_wait_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.stop_wait && wait_mode && !test_mode) |=> $stable(count) && !acc_tick);
endmodule

// File: tb/tb_ptimer_core.sv
`timescale 1ns/100ps
module tb_ptimer_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic wait_mode = 1'b0, test_mode = 1'b0;
  logic [15:0] count;
  logic acc_tick;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptimer_core dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wait_mode(wait_mode), .test_mode(test_mode), .count(count), .acc_tick(acc_tick)
  );

  // Behavioural reference model
  logic [15:0] m_cnt = '0, m_rdata = '0;
  logic [7:0]  m_ctl = '0;
  int          m_div = 0;
  logic        m_tick = 1'b0;
  always @(posedge clk) begin
    logic running;
    logic [15:0] rv;
    if (rst) begin
      m_cnt = '0; m_rdata = '0; m_ctl = '0; m_div = 0; m_tick = 1'b0;
    end else begin
      running = m_ctl[7] && !(m_ctl[6] && wait_mode);
      rv = '0;
      if (bus_rd && bus_addr[2:1] == 2'b10) begin
        if (bus_be[1]) rv[15:8] = m_cnt[15:8];
        if (bus_be[0]) rv[7:0]  = m_cnt[7:0];
      end else if (bus_rd && bus_addr[2:1] == 2'b11 && bus_be[1]) begin
        rv[15:8] = m_ctl & 8'hF8;
      end
      m_rdata = rv;
      m_tick = running && (m_div == 63);
      if (bus_wr && test_mode && bus_addr[2:1] == 2'b10 && bus_be != 2'b00) begin
        if (bus_be[1]) m_cnt[15:8] = bus_wdata[15:8];
        if (bus_be[0]) m_cnt[7:0]  = bus_wdata[7:0];
      end else if (running) begin
        m_cnt = m_cnt + 16'd1;
      end
      if (running) m_div = (m_div + 1) % 64;
      if (bus_wr && bus_addr[2:1] == 2'b11 && bus_be[1]) m_ctl = bus_wdata[15:8] & 8'hF8;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(count == m_cnt, "R2 R3 R4 R9 count", count, m_cnt);
      check(acc_tick == m_tick, "R5 tick", acc_tick, m_tick);
      check(bus_rdata == m_rdata, "R6 R7 R10 R11 rdata", bus_rdata, m_rdata);
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus(input bit w, input logic [2:0] a, input logic [1:0] be,
                     input logic [15:0] d);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = w; bus_rd = !w;
    cyc();
    bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  initial begin
    fork
      begin
        cyc(5000);
        if (!done) begin
          fails++; checks++;
          $display("FAIL watchdog expired");
          done = 1'b1;
          $display("%0d/%0d checks passed", checks - fails, checks);
          $finish;
        end
      end
    join_none
  end

  initial begin
    logic [15:0] c;
    int ticks;
    cyc(4);
    rst = 1'b0;
    cyc();
    check(count == 16'h0 && acc_tick == 1'b0 && bus_rdata == 16'h0, "R1 reset", count, 0);

    cyc(70);
    check(count == 16'h0, "R3 disabled hold", count, 0);

    bus(1'b1, 3'd6, 2'b10, 16'h8000);             // enable
    cyc(150);
    ticks = 0;
    for (int i = 0; i < 128; i++) begin cyc(); if (acc_tick) ticks++; end
    check(ticks == 2, "R5 tick rate", ticks, 2);

    c = count; bus(1'b0, 3'd4, 2'b11, 16'h0);
    check(bus_rdata == c, "R6 word read", bus_rdata, c);
    c = count; bus(1'b0, 3'd4, 2'b10, 16'h0);
    check(bus_rdata == {c[15:8], 8'h00}, "R7 high byte", bus_rdata, {c[15:8], 8'h00});
    c = count; bus(1'b0, 3'd5, 2'b01, 16'h0);
    check(bus_rdata == {8'h00, c[7:0]}, "R7 low byte", bus_rdata, {8'h00, c[7:0]});
    cyc();
    check(bus_rdata == 16'h0, "R11 idle rdata", bus_rdata, 0);

    wait_mode = 1'b1;
    c = count; cyc(10);
    check(count == c + 16'd10, "R4 runs in wait", count, c + 16'd10);
    bus(1'b1, 3'd6, 2'b10, 16'hC000);             // set stop-in-wait
    cyc();
    c = count; ticks = 0;
    for (int i = 0; i < 80; i++) begin cyc(); if (acc_tick) ticks++; end
    check(count == c && ticks == 0, "R4 frozen in wait", count, c);
    wait_mode = 1'b0;
    cyc(37);

    bus(1'b1, 3'd6, 2'b10, 16'h0000);             // disable
    cyc();
    c = count;
    bus(1'b1, 3'd4, 2'b11, 16'h1234);
    cyc(3);
    check(count == c, "R8 normal-mode write ignored", count, c);
    bus(1'b1, 3'd6, 2'b10, 16'h8000);
    cyc(20);

    test_mode = 1'b1;
    bus(1'b1, 3'd4, 2'b11, 16'hFFFE);
    check(count == 16'hFFFE, "R9 word load", count, 16'hFFFE);
    cyc();
    check(count == 16'hFFFF, "R2 before wrap", count, 16'hFFFF);
    cyc();
    check(count == 16'h0000, "R2 wrap", count, 0);
    c = count;
    bus(1'b1, 3'd4, 2'b10, 16'hAB55);
    check(count == {8'hAB, c[7:0]}, "R9 high lane load", count, {8'hAB, c[7:0]});
    test_mode = 1'b0;
    cyc(90);

    bus(1'b1, 3'd6, 2'b10, 16'hFF00);
    bus(1'b0, 3'd6, 2'b10, 16'h0);
    check(bus_rdata == 16'hF800, "R10 control readback", bus_rdata, 16'hF800);
    bus(1'b1, 3'd6, 2'b01, 16'h00FF);
    bus(1'b0, 3'd6, 2'b11, 16'h0);
    check(bus_rdata == 16'hF800, "R10 low lane ignored", bus_rdata, 16'hF800);
    cyc(10);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule